// File: doc/BRIEF.md
# Timed Power-Rail Enable Sequencer

This block switches on a chain of supply rails one after another. A start request (an edge, captured in a latch) combined with an upstream power-good signal forms the sequence enable. Once enabled, the block raises the first rail enable and waits for that rail's power-good. If power-good does not arrive within a timeout, the block declares a fault. If it does arrive, the block waits a fixed settling time and then raises the next enable. The last rail of the chain has no power-good input: once it is raised, the chain is complete.

A separate final-rail enable is meant for a sensitive amplifier drain supply. It is the AND of a second request latch and the last chain enable. Software may issue that request before or after the chain completes, and the final rail comes up only when both conditions hold. If the sequence enable drops, the block lowers the chain enables in reverse order, one per clock. A timeout fault does the same and then holds the block until a clear pulse. All delays are cycle counts derived from the clock frequency parameter. The defaults give 47000 cycles for the timeout and 2200 cycles for the settling time at 1 MHz.

The controller is a state machine with these states:
- **ST_IDLE**: all rails off.
- **ST_WAIT_PG**: the current rail is on and its timeout is running.
- **ST_SETTLE**: the current rail is good and the settling time is running.
- **ST_RUN**: the whole chain is on.
- **ST_RAMP_DN**: rails are dropping from the top down.
- **ST_FAULT**: all rails are off and the fault is held.

Its transitions are:
- **start**: ST_IDLE to ST_WAIT_PG, when enabled and no fault is held.
- **pg_ok**: ST_WAIT_PG to ST_SETTLE.
- **timeout**: ST_WAIT_PG to ST_RAMP_DN, setting the fault.
- **next_rail**: ST_SETTLE to ST_WAIT_PG.
- **chain_done**: ST_SETTLE to ST_RUN, when the top rail is raised.
- **abort**: from ST_WAIT_PG, ST_SETTLE or ST_RUN to ST_RAMP_DN, when the sequence enable is low.
- **ramp_end**: ST_RAMP_DN to ST_IDLE, or to ST_FAULT if a fault is held.
- **cleared**: ST_FAULT to ST_IDLE, once the fault flag is clear.

Top module: `pwr_rail_sequencer`

## Requirements
- R1: A rising edge of `start_req_i` sets a start latch, and only `clr_i` clears it. A request held high does not set the latch again after a clear. `seq_en_o` is that latch ANDed with `upstream_pg_i`, which passes through two synchronizer flops first. `rail_en_o[0]` rises on the clock edge after `seq_en_o` is first high, and no enable rises while `seq_en_o` is low.
- R2: Rail enables rise strictly in index order, bit 0 first. `rail_en_o` is always a contiguous run of ones starting at bit 0.
- R3: Rail k (k < N_RAILS-1) passes if its raw power-good is first sampled high no later than the (TIMEOUT_CYC-1)-th edge after its enable rose. Otherwise `fault_o` rises on the (TIMEOUT_CYC+1)-th edge after its enable rose.
- R4: When rail k passes, `rail_en_o[k+1]` rises on the (SETTLE_CYC+3)-th edge after the first edge that sampled rail k's raw power-good high.
- R5: After a fault, the raised enables fall one per clock, top bit first. The fault flag stays set, and no rail is raised again while it is set, even if `seq_en_o` stays high.
- R6: A clear pulse on `clr_i` clears the fault flag and both request latches, and it takes priority over a fault set in the same cycle.
- R7: A rising edge of `final_req_i` sets a final latch. `final_en_o` is that latch ANDed with the top chain enable, so a request made before the chain completes takes effect in the same cycle the top enable rises.
- R8: After reset all outputs are low. `seq_done_o` is high exactly while the top chain enable is high.
- R9: When `seq_en_o` falls, the block lowers the enables one per clock, top first, starting two edges later. `final_en_o` and `seq_done_o` fall with the top enable, and no fault is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Synchronous clear pulse for the fault flag and request latches |
| start_req_i | input | 1 | Sequence start request; its rising edge is latched |
| upstream_pg_i | input | 1 | Upstream (hot-swap) power-good, asynchronous |
| rail_pg_i | input | N_RAILS-1 | Power-good of chain rails 0..N_RAILS-2, asynchronous |
| final_req_i | input | 1 | Final-rail request; its rising edge is latched |
| rail_en_o | output | N_RAILS | Chain rail enables |
| final_en_o | output | 1 | Final (amplifier drain) rail enable |
| seq_en_o | output | 1 | Sequence enable status |
| seq_done_o | output | 1 | Chain complete status |
| fault_o | output | 1 | Sticky timeout fault |

## Verification
The assertions assume that `clr_i`, `start_req_i` and `final_req_i` are synchronous to `clk`, since their edges are detected without synchronizers. They also assume that a clear pulse is the only way the fault flag is expected to fall. The power-good inputs may change at any time. The stimulus changes every input only at the falling clock edge. It drives power-good from a small rail model that raises each rail's power-good a chosen number of cycles after its enable, sweeping that delay across the whole accepted window and onto the first failing value.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_WAIT_PG = 3'd1,
        ST_SETTLE  = 3'd2,
        ST_RUN     = 3'd3,
        ST_RAMP_DN = 3'd4,
        ST_FAULT   = 3'd5
    } seq_state_e;

    function automatic int unsigned us_to_cycles(input int unsigned clk_hz, input int unsigned us);
        return (clk_hz / 1_000_000) * us;
    endfunction

endpackage

// File: rtl/pwr_seq_sync2.sv
module pwr_seq_sync2 #(
    parameter int WIDTH = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    genvar g;
    generate
        for (g = 0; g < WIDTH; g++) begin : g_bit
            logic meta_q;
            logic stable_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    meta_q   <= 1'b0;
                    stable_q <= 1'b0;
                end else begin
                    meta_q   <= async_i[g];
                    stable_q <= meta_q;
                end
            end
            assign sync_o[g] = stable_q;
        end
    endgenerate
endmodule

// File: rtl/pwr_seq_edge_latch.sv
module pwr_seq_edge_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic req_i,
    output logic held_o
);
    logic prev_q;
    logic held_q;
    logic rise;

    assign rise = req_i & ~prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            held_q <= 1'b0;
        end else begin
            prev_q <= req_i;
            if (clr_i) begin
                held_q <= 1'b0;
            end else if (rise) begin
                held_q <= 1'b1;
            end
        end
    end

    assign held_o = held_q;
endmodule

// File: rtl/pwr_seq_timer.sv
module pwr_seq_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             expired_o
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/pwr_rail_sequencer.sv
module pwr_rail_sequencer
    import pwr_seq_pkg::*;
#(
    parameter int N_RAILS    = 4,
    parameter int CLK_HZ     = 1_000_000,
    parameter int TIMEOUT_US = 47000,
    parameter int SETTLE_US  = 2200
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr_i,
    input  logic               start_req_i,
    input  logic               upstream_pg_i,
    input  logic [N_RAILS-2:0] rail_pg_i,
    input  logic               final_req_i,
    output logic [N_RAILS-1:0] rail_en_o,
    output logic               final_en_o,
    output logic               seq_en_o,
    output logic               seq_done_o,
    output logic               fault_o
);
    localparam int TIMEOUT_CYC = int'(us_to_cycles(CLK_HZ, TIMEOUT_US));
    localparam int SETTLE_CYC  = int'(us_to_cycles(CLK_HZ, SETTLE_US));
    localparam int MAX_CYC     = (TIMEOUT_CYC > SETTLE_CYC) ? TIMEOUT_CYC : SETTLE_CYC;
    localparam int CNT_W       = $clog2(MAX_CYC + 1);
    localparam int IDX_W       = (N_RAILS > 2) ? $clog2(N_RAILS) : 1;
    localparam logic [CNT_W-1:0] TIMEOUT_VAL = CNT_W'(TIMEOUT_CYC);
    localparam logic [CNT_W-1:0] SETTLE_VAL  = CNT_W'(SETTLE_CYC);
    localparam logic [IDX_W-1:0] LAST_PG_IDX = IDX_W'(N_RAILS - 2);

    seq_state_e         state_q, state_d;
    logic [IDX_W-1:0]   idx_q, idx_d;
    logic [N_RAILS-1:0] en_q, en_d;
    logic               fault_q, fault_d;

    logic               start_held;
    logic               final_held;
    logic               up_pg_sync;
    logic [N_RAILS-2:0] rail_pg_sync;
    logic [N_RAILS-1:0] pg_pad;
    logic               seq_en;
    logic               tmr_load;
    logic [CNT_W-1:0]   tmr_val;
    logic               tmr_expired;

    pwr_seq_sync2 #(.WIDTH(1)) up_sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (upstream_pg_i),
        .sync_o  (up_pg_sync)
    );

    pwr_seq_sync2 #(.WIDTH(N_RAILS - 1)) rail_sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (rail_pg_i),
        .sync_o  (rail_pg_sync)
    );

    pwr_seq_edge_latch start_latch_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (clr_i),
        .req_i  (start_req_i),
        .held_o (start_held)
    );

    pwr_seq_edge_latch final_latch_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (clr_i),
        .req_i  (final_req_i),
        .held_o (final_held)
    );

    pwr_seq_timer #(.CNT_W(CNT_W)) timer_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .expired_o  (tmr_expired)
    );

    assign seq_en = start_held & up_pg_sync;
    assign pg_pad = {1'b0, rail_pg_sync};

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            en_q    <= '0;
            fault_q <= 1'b0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            en_q    <= en_d;
            fault_q <= fault_d;
        end
    end

    // Next-state and sequencing decisions
    always_comb begin
        state_d  = state_q;
        idx_d    = idx_q;
        en_d     = en_q;
        fault_d  = fault_q;
        tmr_load = 1'b0;
        tmr_val  = TIMEOUT_VAL;
        unique case (state_q)
            ST_IDLE: begin
                if (seq_en && !fault_q) begin
                    en_d[0]  = 1'b1;
                    idx_d    = '0;
                    tmr_load = 1'b1;
                    tmr_val  = TIMEOUT_VAL;
                    state_d  = ST_WAIT_PG;
                end
            end
            ST_WAIT_PG: begin
                if (!seq_en) begin
                    state_d = ST_RAMP_DN;
                end else if (pg_pad[idx_q]) begin
                    tmr_load = 1'b1;
                    tmr_val  = SETTLE_VAL;
                    state_d  = ST_SETTLE;
                end else if (tmr_expired) begin
                    fault_d = 1'b1;
                    state_d = ST_RAMP_DN;
                end
            end
            ST_SETTLE: begin
                if (!seq_en) begin
                    state_d = ST_RAMP_DN;
                end else if (tmr_expired) begin
                    en_d[idx_q + 1'b1] = 1'b1;
                    idx_d              = idx_q + 1'b1;
                    if (idx_q == LAST_PG_IDX) begin
                        state_d = ST_RUN;
                    end else begin
                        tmr_load = 1'b1;
                        tmr_val  = TIMEOUT_VAL;
                        state_d  = ST_WAIT_PG;
                    end
                end
            end
            ST_RUN: begin
                if (!seq_en) begin
                    state_d = ST_RAMP_DN;
                end
            end
            ST_RAMP_DN: begin
                if (en_q == '0) begin
                    state_d = fault_q ? ST_FAULT : ST_IDLE;
                end else begin
                    en_d = en_q >> 1;
                end
            end
            ST_FAULT: begin
                if (!fault_q) begin
                    state_d = ST_IDLE;
                end
            end
            default: begin
                state_d = ST_IDLE;
                en_d    = '0;
            end
        endcase
        if (clr_i) begin
            fault_d = 1'b0;
        end
    end

    // Outputs
    always_comb begin
        rail_en_o  = en_q;
        final_en_o = final_held & en_q[N_RAILS-1];
        seq_en_o   = seq_en;
        seq_done_o = en_q[N_RAILS-1];
        fault_o    = fault_q;
    end
endmodule

// File: rtl/pwr_rail_sequencer_chk.sv
module pwr_rail_sequencer_chk #(
    parameter int N_RAILS = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               clr_i,
    input logic [N_RAILS-1:0] rail_en_o,
    input logic               final_en_o,
    input logic               seq_en_o,
    input logic               seq_done_o,
    input logic               fault_o
);
    logic [N_RAILS-1:0] en_inc;
    assign en_inc = rail_en_o + {{(N_RAILS-1){1'b0}}, 1'b1};

    a_r2_contiguous_enables: assert property (@(posedge clk) disable iff (!rst_n)
        (en_inc & rail_en_o) == '0);

    a_r2_one_rail_per_step: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(rail_en_o) <= $countones($past(rail_en_o)) + 1);

    a_r1_no_rise_without_enable: assert property (@(posedge clk) disable iff (!rst_n)
        !seq_en_o |=> $countones(rail_en_o) <= $countones($past(rail_en_o)));

    a_r5_no_rise_while_faulted: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |=> $countones(rail_en_o) <= $countones($past(rail_en_o)));

    a_r5_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_o && !clr_i) |=> fault_o);

    a_r6_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !fault_o);

    a_r9_single_step_down: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(rail_en_o) + 1 >= $countones($past(rail_en_o)));

    a_r7_final_needs_chain: assert property (@(posedge clk) disable iff (!rst_n)
        final_en_o |-> (seq_done_o && rail_en_o[N_RAILS-1]));

    a_r8_done_means_all_on: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done_o |-> (&rail_en_o));
endmodule

bind pwr_rail_sequencer pwr_rail_sequencer_chk #(.N_RAILS(N_RAILS)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (clr_i),
    .rail_en_o  (rail_en_o),
    .final_en_o (final_en_o),
    .seq_en_o   (seq_en_o),
    .seq_done_o (seq_done_o),
    .fault_o    (fault_o)
);

// File: tb/pwr_rail_sequencer_tb_top.sv
module pwr_rail_sequencer_tb_top;
    localparam int N   = 4;
    localparam int HZ  = 1_000_000;
    localparam int TUS = 12;
    localparam int SUS = 5;
    localparam int V   = TUS * (HZ / 1_000_000);
    localparam int S   = SUS * (HZ / 1_000_000);

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         clr = 1'b0;
    logic         start_req = 1'b0;
    logic         up_pg = 1'b0;
    logic         final_req = 1'b0;
    logic [N-2:0] rail_pg = '0;
    logic [N-1:0] rail_en;
    logic         final_en, seq_en, seq_done, fault;

    int n_cmp = 0;
    int n_bad = 0;
    bit over  = 1'b0;

    pwr_rail_sequencer #(
        .N_RAILS(N), .CLK_HZ(HZ), .TIMEOUT_US(TUS), .SETTLE_US(SUS)
    ) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .clr_i         (clr),
        .start_req_i   (start_req),
        .upstream_pg_i (up_pg),
        .rail_pg_i     (rail_pg),
        .final_req_i   (final_req),
        .rail_en_o     (rail_en),
        .final_en_o    (final_en),
        .seq_en_o      (seq_en),
        .seq_done_o    (seq_done),
        .fault_o       (fault)
    );

    always #10 clk = ~clk;

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic pulse_clr();
        clr = 1'b1;
        tick();
        clr = 1'b0;
    endtask

    task automatic start_seq();
        start_req = 1'b1;
        tick();
        start_req = 1'b0;
        chk("R1", "seq_en after start edge", int'(seq_en), 1);
        tick();
        chk("R1", "first rail enable", int'(rail_en), 1);
    endtask

    // Starts at the negedge where rail k was first seen enabled
    task automatic step_rail(input int k, input int d);
        repeat (d) tick();
        rail_pg[k] = 1'b1;
        repeat (S + 3) tick();
        chk("R4", "next enable not yet", int'(rail_en[k+1]), 0);
        tick();
        chk("R4", "next enable rises", int'(rail_en[k+1]), 1);
        chk("R2", "enable pattern", int'(rail_en), (1 << (k + 2)) - 1);
    endtask

    task automatic bring_up(input int d, input bit early_final);
        if (early_final) begin
            final_req = 1'b1;
            tick();
            final_req = 1'b0;
            chk("R7", "final off before chain", int'(final_en), 0);
        end
        start_seq();
        for (int k = 0; k < N - 1; k++) begin
            step_rail(k, d);
        end
        chk("R8", "done at chain end", int'(seq_done), 1);
        chk("R3", "no fault inside window", int'(fault), 0);
        chk("R7", "final follows early request", int'(final_en), int'(early_final));
    endtask

    task automatic tear_down();
        pulse_clr();
        chk("R6", "clear drops seq_en", int'(seq_en), 0);
        rail_pg = '0;
        repeat (8) tick();
        chk("R6", "rails off after clear", int'(rail_en), 0);
        chk("R8", "done low after teardown", int'(seq_done), 0);
        chk("R7", "final low after teardown", int'(final_en), 0);
    endtask

    task automatic fault_case(input int k, input bit never);
        start_seq();
        for (int r = 0; r < k; r++) begin
            step_rail(r, 0);
        end
        repeat (V - 1) tick();
        if (!never) rail_pg[k] = 1'b1;
        tick();
        chk("R3", "no fault at edge TIMEOUT", int'(fault), 0);
        tick();
        chk("R3", "fault at edge TIMEOUT+1", int'(fault), 1);
        chk("R5", "rails held at fault", int'(rail_en), (1 << (k + 1)) - 1);
        for (int m = 1; m <= k + 1; m++) begin
            tick();
            chk("R5", "reverse ramp step", int'(rail_en), (1 << (k + 1 - m)) - 1);
        end
        repeat (6) tick();
        chk("R5", "no restart while faulted", int'(rail_en), 0);
        chk("R5", "fault sticky", int'(fault), 1);
        chk("R5", "seq_en still high", int'(seq_en), 1);
        pulse_clr();
        chk("R6", "fault cleared", int'(fault), 0);
        chk("R6", "start latch cleared", int'(seq_en), 0);
        rail_pg = '0;
        repeat (4) tick();
        chk("R6", "idle after clear", int'(rail_en), 0);
    endtask

    initial begin
        repeat (3) tick();
        chk("R8", "reset rails", int'(rail_en), 0);
        chk("R8", "reset flags", int'({final_en, seq_en, seq_done, fault}), 0);
        rst_n = 1'b1;
        tick();

        // R1: upstream power-good gates the sequence
        start_req = 1'b1;
        tick();
        start_req = 1'b0;
        repeat (5) tick();
        chk("R1", "no seq_en without upstream", int'(seq_en), 0);
        chk("R1", "no rails without upstream", int'(rail_en), 0);
        up_pg = 1'b1;
        tick();
        chk("R1", "seq_en after one sync edge", int'(seq_en), 0);
        tick();
        chk("R1", "seq_en after two sync edges", int'(seq_en), 1);
        tick();
        chk("R1", "first rail after seq_en", int'(rail_en), 1);
        tear_down();

        // R3/R4: sweep acceptance delay across the whole window
        for (int d = 0; d <= V - 2; d++) begin
            bring_up(d, (d % 2) == 1);
            tear_down();
        end

        // R3/R5/R6: timeout on every checked rail, boundary and absent
        for (int k = 0; k < N - 1; k++) begin
            fault_case(k, 1'b0);
            fault_case(k, 1'b1);
        end

        // R7: late final request
        bring_up(2, 1'b0);
        repeat (5) tick();
        chk("R7", "final off without request", int'(final_en), 0);
        final_req = 1'b1;
        tick();
        chk("R7", "final on after late request", int'(final_en), 1);
        final_req = 1'b0;
        tick();
        chk("R7", "final latched", int'(final_en), 1);
        tear_down();

        // R9: upstream loss while complete
        bring_up(0, 1'b1);
        up_pg = 1'b0;
        tick();
        chk("R9", "seq_en one edge later", int'(seq_en), 1);
        tick();
        chk("R9", "seq_en after sync", int'(seq_en), 0);
        tick();
        chk("R9", "rails before ramp", int'(rail_en), 15);
        chk("R9", "final before ramp", int'(final_en), 1);
        tick();
        chk("R9", "top dropped", int'(rail_en), 7);
        chk("R9", "final with top", int'(final_en), 0);
        chk("R9", "done with top", int'(seq_done), 0);
        tick();
        chk("R9", "third dropped", int'(rail_en), 3);
        tick();
        chk("R9", "second dropped", int'(rail_en), 1);
        tick();
        chk("R9", "all dropped", int'(rail_en), 0);
        chk("R9", "no fault on abort", int'(fault), 0);
        pulse_clr();
        rail_pg = '0;
        up_pg = 1'b1;
        repeat (6) tick();
        chk("R6", "no restart after clear", int'(seq_en), 0);

        // R1: held request does not re-arm after clear
        start_req = 1'b1;
        tick();
        chk("R1", "held request arms once", int'(seq_en), 1);
        pulse_clr();
        repeat (8) tick();
        chk("R1", "held request ignored", int'(seq_en), 0);
        chk("R1", "rails off with held request", int'(rail_en), 0);
        start_req = 1'b0;
        tick();

        if (!over) begin
            over = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!over) begin
            over = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule